// File: doc/BRIEF.md
# Johnson Decade Counter with Gated Seven-Segment Drive

This block counts clock edges modulo ten and shows the current digit on a seven-segment display. The count is kept in a five-bit twisted-ring (Johnson) register rather than in binary. The ring state is decoded directly into active-high segment signals. A clock-inhibit input freezes the count. An active-low asynchronous reset returns it to zero.

The seven segment lines are gated by a display-enable input. This lets the display be switched off to save power, or time-multiplexed between digits. The carry output and an ungated copy of segment c are never gated. Divider chains can therefore use them while the display is dark. The carry output makes one full cycle per ten counted edges. It can clock the next, more significant digit directly. The display-enable input is also passed through to an output so that it can be chained to further digits.

Top module: `jseg_counter`

## Requirements
- R1: While `rst_ni` is low, the count is zero (segments show 0, carry high). The reset acts at once, with no clock edge needed, and it overrides the clock and `inhibit_i`.
- R2: On each rising `clk_i` edge with `inhibit_i` low, the digit advances by one, and 9 is followed by 0.
- R3: On a rising edge with `inhibit_i` high, the count does not change.
- R4: If the ring holds a pattern that is not one of the ten legal codes, all segment outputs read 0. The next rising edge with `inhibit_i` low puts the counter at digit 0.
- R5: `carry_o` is high for digits 0 to 4 and low for digits 5 to 9. Its only rising edge therefore comes on the step from 9 to 0.
- R6: `seg_o` carries segment a in bit 0 through segment g in bit 6, all active high. The patterns for digits 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. Digit 6 includes segment a and digit 9 includes segment d.
- R7: While `disp_en_i` is low, `seg_o` is all zeros whatever the count.
- R8: `seg_c_raw_o` always equals segment c of the current digit, and `carry_o` always follows the count, whatever the level of `disp_en_i`. `disp_en_o` always equals `disp_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inhibit_i | input | 1 | Freezes the count while high |
| disp_en_i | input | 1 | Enables the segment outputs |
| seg_o | output | 7 | Gated segments, bit 0 = a through bit 6 = g |
| seg_c_raw_o | output | 1 | Segment c, never gated |
| carry_o | output | 1 | Carry to the next decade |
| disp_en_o | output | 1 | Copy of disp_en_i |

## Verification
The hardest case to reach is an illegal ring pattern. No sequence of clocks, inhibits and resets can create one from the ports. The bench therefore loads such a pattern into the ring register while reset is held low, with inhibit high. It then releases reset and checks three things at the ports: the segments go blank, an inhibited edge does not change them, and the first free edge shows digit 0. The gated and ungated paths are compared over a full decade with the display disabled.

// File: rtl/jseg_pkg.sv
package jseg_pkg;
  localparam int unsigned STAGES = 5;
  localparam int unsigned DIGITS = 2 * STAGES;
  localparam int unsigned DIG_W  = $clog2(DIGITS);
  localparam int unsigned SEG_W  = 7;

  typedef logic [STAGES-1:0] jstate_t;
  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Ring code for digit d: fill ones from bit 0, then drain them from bit 0
  function automatic jstate_t johnson_code(int unsigned d);
    jstate_t s;
    s = '0;
    for (int unsigned i = 0; i < STAGES; i++) begin
      if (d <= STAGES) s[i] = (i < d);
      else             s[i] = (i >= d - STAGES);
    end
    return s;
  endfunction

  // bit0 = a ... bit6 = g
  function automatic seg_t digit_seg(digit_t d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/jseg_ring.sv
module jseg_ring
  import jseg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    inhibit_i,
  output jstate_t state_o
);
  jstate_t state_q, state_d;
  logic    legal;

  always_comb begin
    legal = 1'b0;
    for (int unsigned k = 0; k < DIGITS; k++)
      if (state_q == johnson_code(k)) legal = 1'b1;
  end

  // Anti-lock: any illegal pattern is replaced by the zero code
  always_comb begin
    if (!legal) state_d = '0;
    else        state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= '0;
    else if (!inhibit_i) state_q <= state_d;
  end

  assign state_o = state_q;

  AST_RESET_ZERO: assert property (@(posedge clk_i) !rst_ni |-> state_q == '0); // R1
  AST_INHIBIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> $stable(state_q)); // R3
endmodule

// File: rtl/jseg_decode.sv
module jseg_decode
  import jseg_pkg::*;
(
  input  jstate_t state_i,
  output digit_t  digit_o,
  output logic    valid_o,
  output seg_t    seg_o
);
  always_comb begin
    digit_o = '0;
    valid_o = 1'b0;
    for (int unsigned k = 0; k < DIGITS; k++) begin
      if (state_i == johnson_code(k)) begin
        digit_o = DIG_W'(k);
        valid_o = 1'b1;
      end
    end
  end

  assign seg_o = valid_o ? digit_seg(digit_o) : '0;
endmodule

// File: rtl/jseg_gate.sv
module jseg_gate
  import jseg_pkg::*;
(
  input  seg_t seg_i,
  input  logic en_i,
  output seg_t seg_o
);
  for (genvar b = 0; b < SEG_W; b++) begin : g_bit
    assign seg_o[b] = seg_i[b] & en_i;
  end
endmodule

// File: rtl/jseg_counter.sv
module jseg_counter
  import jseg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inhibit_i,
  input  logic             disp_en_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             seg_c_raw_o,
  output logic             carry_o,
  output logic             disp_en_o
);
  jstate_t state;
  digit_t  digit;
  logic    valid;
  seg_t    seg_raw;

  jseg_ring u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inhibit_i (inhibit_i),
    .state_o   (state)
  );

  jseg_decode u_dec (
    .state_i (state),
    .digit_o (digit),
    .valid_o (valid),
    .seg_o   (seg_raw)
  );

  jseg_gate u_gate (
    .seg_i (seg_raw),
    .en_i  (disp_en_i),
    .seg_o (seg_o)
  );

  assign carry_o     = ~state[STAGES-1];
  assign seg_c_raw_o = seg_raw[2];
  assign disp_en_o   = disp_en_i;

  AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_i && valid |=> digit == (($past(digit) == DIG_W'(DIGITS-1)) ? '0 : $past(digit) + 1'b1)); // R2
  AST_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_i |=> valid); // R4
  AST_CARRY_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> carry_o == (digit < DIG_W'(STAGES))); // R5
  AST_SEG_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_i |-> seg_o == '0); // R7
  AST_SEG_C_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> seg_c_raw_o == digit_seg(digit)[2]); // R8
endmodule

// File: tb/tb_jseg_counter.sv
module tb_jseg_counter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       inhibit = 1'b0;
  logic       den = 1'b1;
  logic [6:0] seg;
  logic       seg_c_raw, carry, den_o;
  int         checks = 0;
  int         errors = 0;
  int         exp_d = 0;

  always #4 clk = ~clk;

  jseg_counter dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .inhibit_i   (inhibit),
    .disp_en_i   (den),
    .seg_o       (seg),
    .seg_c_raw_o (seg_c_raw),
    .carry_o     (carry),
    .disp_en_o   (den_o)
  );

  function automatic logic [6:0] ref_seg(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_digit(int d, string req);
    check({25'd0, seg}, {25'd0, (den ? ref_seg(d) : 7'h00)}, req);
    check({31'd0, carry}, {31'd0, (d < 5)}, {req, "/R5"});
    check({31'd0, seg_c_raw}, {31'd0, ref_seg(d)[2]}, {req, "/R8"});
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    step(3);
    exp_d = 0;
    check_digit(0, "R1 reset");
    inhibit = 1'b0;
    step(1);
    check_digit(0, "R1 clock ignored in reset");
    rst_ni = 1'b1;
    step(1);
    exp_d = 1;
    check_digit(exp_d, "R2 first count");
  endtask

  task automatic t_count;
    logic prev_c;
    for (int i = 0; i < 25; i++) begin
      prev_c = carry;
      step(1);
      exp_d = (exp_d + 1) % 10;
      check_digit(exp_d, "R2/R6 count");
      if (!prev_c && carry) check(exp_d, 0, "R5 carry rise at wrap");
    end
  endtask

  task automatic t_inhibit;
    inhibit = 1'b1;
    step(4);
    check_digit(exp_d, "R3 inhibit hold");
    inhibit = 1'b0;
    step(1);
    exp_d = (exp_d + 1) % 10;
    check_digit(exp_d, "R3 resume");
  endtask

  task automatic t_display;
    den = 1'b0;
    #1;
    check({31'd0, den_o}, 32'd0, "R8 den_o low");
    for (int i = 0; i < 10; i++) begin
      step(1);
      exp_d = (exp_d + 1) % 10;
      check_digit(exp_d, "R7 blank");
    end
    den = 1'b1;
    #1;
    check({31'd0, den_o}, 32'd1, "R8 den_o high");
    check_digit(exp_d, "R7 restore");
  endtask

  task automatic t_async_reset;
    step(3);
    exp_d = (exp_d + 3) % 10;
    if (exp_d == 0) begin
      step(1);
      exp_d = 1;
    end
    #1;
    rst_ni = 1'b0;
    #1;
    exp_d = 0;
    check_digit(0, "R1 async");
    step(1);
    rst_ni = 1'b1;
  endtask

  task automatic t_illegal;
    rst_ni  = 1'b0;
    inhibit = 1'b1;
    step(1);
    force dut.u_ring.state_q = 5'b01010;
    #1;
    release dut.u_ring.state_q;
    rst_ni = 1'b1;
    #1;
    check({25'd0, seg}, 32'd0, "R4 illegal blank");
    step(1);
    check({25'd0, seg}, 32'd0, "R4 illegal held under inhibit");
    inhibit = 1'b0;
    step(1);
    exp_d = 0;
    check_digit(0, "R4 recover to zero");
    step(1);
    exp_d = 1;
    check_digit(1, "R4 count after recover");
  endtask

  initial begin
    #2;
    t_reset();
    t_count();
    t_inhibit();
    t_display();
    t_async_reset();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule